// File: doc/BRIEF.md
# Receive High Bit-Error-Rate Monitor (64b/66b links)

This block watches the two-bit synchronisation header of every received 66-bit block on a 10 Gb/s Ethernet style receive path. One header arrives with each pulse of a valid strobe. A block-lock input comes from the upstream block synchroniser. While lock is held, the monitor divides time into back-to-back windows of fixed length. In each window it counts the headers that are neither of the two legal codes. When a window collects more invalid headers than a threshold, it raises a high-error-rate flag for the user logic.

The window length is a parameter in clock cycles. The nominal 125 µs window is 19532 cycles at 156.25 MHz, and a much shorter value suits simulation. The threshold defaults to 16, and the comparison is strictly greater-than. The flag sets the moment the threshold is crossed. It is re-judged at every window boundary and cleared at once when lock drops. Lock acquisition, descrambling and block decoding happen elsewhere.

Top module: `hber_monitor`

## Requirements
- R1: While reset is high, and on the first cycle after it, `hi_ber_o` is 0. The error count and window position are cleared.
- R2: A strobed header of 2'b01 or 2'b10 is valid and is never counted.
- R3: A strobed header of 2'b00 or 2'b11 is invalid and adds one to the current window's count while lock is high.
- R4: A header presented while `hdr_vld_i` is 0 has no effect, whatever its value.
- R5: `hi_ber_o` goes to 1 on the cycle after the clock edge that samples the (THRESH+1)-th invalid header of a window. With the default this is the 17th header.
- R6: A window that collects exactly THRESH invalid headers (16 by default), or fewer, never sets the flag.
- R7: A window spans WIN_CYCLES clock edges with lock high. The first window starts at the first edge that samples lock high. The count returns to zero at each boundary. A header sampled on a window's last edge belongs to that window.
- R8: At a window's last edge, the flag is held at 1 if that window's count exceeds THRESH and cleared to 0 otherwise.
- R9: When lock is sampled low, the flag is 0 on the next cycle. The count is cleared, and the window restarts when lock returns.
- R10: The error count saturates at its maximum instead of wrapping. A window with far more invalid headers than THRESH still keeps the flag set at its end.
- R11: Invalid headers strobed while lock is low are not counted toward any later window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_lock_i | input | 1 | Block lock from the synchroniser; monitoring runs only while high |
| hdr_vld_i | input | 1 | Strobe: `hdr_i` carries a block header this cycle |
| hdr_i | input | 2 | Sync header of the current block |
| hi_ber_o | output | 1 | High bit-error-rate flag |

## Verification
The main stimulus is a sweep of 0 to 20 invalid headers per window, using each of the two illegal codes. The headers are packed either at the front or at the back of the window, and legal or unstrobed headers fill the remaining slots. Front packing shows the exact cycle the flag sets, and 16 against 17 separates strict from non-strict comparison. Back packing puts invalid headers on the window's last edge, which exposes an off-by-one in the boundary. Directed sequences split one burst across a boundary, strobe illegal codes with the strobe low or with lock low, drop lock while the flag is set, and fill a whole window with errors to tell saturation from wrap-around.

// File: rtl/hber_pkg.sv
package hber_pkg;

    // Two-bit block header codes
    typedef enum logic [1:0] {
        SH_ILL_LO = 2'b00,
        SH_DATA   = 2'b01,
        SH_CTRL   = 2'b10,
        SH_ILL_HI = 2'b11
    } sync_hdr_e;

    // One header sample as seen at the block input
    typedef struct packed {
        logic      vld;
        sync_hdr_e code;
    } hdr_sample_t;

    // Monitor state that gates all counting
    typedef enum logic {
        MON_IDLE = 1'b0,
        MON_RUN  = 1'b1
    } mon_state_e;

    function automatic logic hdr_is_bad(input sync_hdr_e code);
        return (code == SH_ILL_LO) || (code == SH_ILL_HI);
    endfunction

    function automatic logic sample_is_hit(input hdr_sample_t s, input mon_state_e st);
        return (st == MON_RUN) && s.vld && hdr_is_bad(s.code);
    endfunction

endpackage

// File: rtl/hber_window_timer.sv
module hber_window_timer
    import hber_pkg::*;
#(
    parameter int WIN_CYCLES = 19532,
    localparam int WIN_W     = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  mon_state_e       state_i,
    output logic             win_end_o,
    output logic [WIN_W-1:0] win_cnt_o
);

    localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYCLES - 1);

    logic [WIN_W-1:0] pos_q;
    logic             at_last;

    assign at_last   = (pos_q == LAST);
    assign win_end_o = (state_i == MON_RUN) && at_last;
    assign win_cnt_o = pos_q;

    always_ff @(posedge clk) begin
        if (rst || state_i == MON_IDLE) begin
            pos_q <= '0;
        end else if (at_last) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

endmodule

// File: rtl/hber_err_counter.sv
module hber_err_counter
    import hber_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  mon_state_e       state_i,
    input  logic             win_end_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] inc;

    // Saturating increment: the count sticks at all-ones
    always_comb begin
        if (cnt_q == CNT_MAX) begin
            inc = cnt_q;
        end else begin
            inc = cnt_q + 1'b1;
        end
        cnt_nxt_o = hit_i ? inc : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst || state_i == MON_IDLE) begin
            cnt_q <= '0;
        end else if (win_end_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt_o;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/hber_flag_ctl.sv
module hber_flag_ctl
    import hber_pkg::*;
#(
    parameter int THRESH = 16,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  mon_state_e       state_i,
    input  logic             win_end_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    output logic             flag_o
);

    localparam logic [CNT_W-1:0] THR_V = CNT_W'(THRESH);

    logic flag_q;
    logic over;

    assign over = (cnt_nxt_i > THR_V);

    always_ff @(posedge clk) begin
        if (rst || state_i == MON_IDLE) begin
            flag_q <= 1'b0;
        end else if (win_end_i) begin
            flag_q <= over;
        end else if (over) begin
            flag_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/hber_monitor.sv
module hber_monitor
    import hber_pkg::*;
#(
    parameter int WIN_CYCLES = 19532,
    parameter int THRESH     = 16,
    localparam int CNT_W     = $clog2(THRESH + 2),
    localparam int WIN_W     = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       blk_lock_i,
    input  logic       hdr_vld_i,
    input  logic [1:0] hdr_i,
    output logic       hi_ber_o
);

    mon_state_e       state;
    hdr_sample_t      smp;
    logic             hit;
    logic             win_end;
    logic [WIN_W-1:0] win_cnt;
    logic [CNT_W-1:0] err_cnt;
    logic [CNT_W-1:0] err_nxt;

    assign state = blk_lock_i ? MON_RUN : MON_IDLE;
    assign smp   = '{vld: hdr_vld_i, code: sync_hdr_e'(hdr_i)};
    assign hit   = sample_is_hit(smp, state);

    hber_window_timer #(
        .WIN_CYCLES(WIN_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .state_i  (state),
        .win_end_o(win_end),
        .win_cnt_o(win_cnt)
    );

    hber_err_counter #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .state_i  (state),
        .win_end_i(win_end),
        .hit_i    (hit),
        .cnt_o    (err_cnt),
        .cnt_nxt_o(err_nxt)
    );

    hber_flag_ctl #(
        .THRESH(THRESH),
        .CNT_W (CNT_W)
    ) u_flag (
        .clk      (clk),
        .rst      (rst),
        .state_i  (state),
        .win_end_i(win_end),
        .cnt_nxt_i(err_nxt),
        .flag_o   (hi_ber_o)
    );

endmodule

// File: rtl/hber_monitor_chk.sv
module hber_monitor_chk #(
    parameter int CNT_W = 5,
    parameter int WIN_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             blk_lock_i,
    input logic             hdr_vld_i,
    input logic [1:0]       hdr_i,
    input logic             hi_ber_o,
    input logic             win_end,
    input logic [CNT_W-1:0] err_cnt,
    input logic [WIN_W-1:0] win_cnt
);

    logic bad_in;
    assign bad_in = blk_lock_i && hdr_vld_i && (hdr_i == 2'b00 || hdr_i == 2'b11);

    // R1
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!hi_ber_o && err_cnt == '0));

    // R2 / R4: count moves only on a strobed invalid header
    p_count_only_bad_r2: assert property (@(posedge clk) disable iff (rst)
        (blk_lock_i && !win_end && !bad_in) |=> $stable(err_cnt));

    // R5
    p_rise_on_bad_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_ber_o) |-> $past(bad_in));

    // R7
    p_boundary_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (blk_lock_i && win_end) |=> (err_cnt == '0 && win_cnt == '0));

    // R8
    p_fall_at_edge_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(hi_ber_o) |-> $past(!blk_lock_i || win_end));

    // R9
    p_unlock_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !blk_lock_i |=> (!hi_ber_o && err_cnt == '0 && win_cnt == '0));

    // R10
    p_sat_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (blk_lock_i && !win_end && err_cnt == '1) |=> (err_cnt == '1));

endmodule

bind hber_monitor hber_monitor_chk #(
    .CNT_W(CNT_W),
    .WIN_W(WIN_W)
) i_hber_monitor_chk (
    .clk       (clk),
    .rst       (rst),
    .blk_lock_i(blk_lock_i),
    .hdr_vld_i (hdr_vld_i),
    .hdr_i     (hdr_i),
    .hi_ber_o  (hi_ber_o),
    .win_end   (win_end),
    .err_cnt   (err_cnt),
    .win_cnt   (win_cnt)
);

// File: tb/test_hber_monitor.sv
module test_hber_monitor;

    localparam int WIN = 40;
    localparam int THR = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lock = 1'b0;
    logic       vld = 1'b0;
    logic [1:0] hdr = 2'b01;
    logic       hi_ber;

    int nvec  = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    hber_monitor #(
        .WIN_CYCLES(WIN),
        .THRESH    (THR)
    ) i_hber_monitor (
        .clk       (clk),
        .rst       (rst),
        .blk_lock_i(lock),
        .hdr_vld_i (vld),
        .hdr_i     (hdr),
        .hi_ber_o  (hi_ber)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: hi_ber=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive at a falling edge, return at the next falling edge
    task automatic step(input logic l, input logic v, input logic [1:0] h);
        lock = l; vld = v; hdr = h;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic unlock_one();
        step(1'b0, 1'b0, 2'b01);
    endtask

    // One full window: bad headers at the front or back, legal/unstrobed filler
    task automatic run_window(input int nbad, input logic [1:0] code,
                              input logic at_back, input string tag);
        int seen = 0;
        for (int c = 0; c < WIN; c++) begin
            logic bad;
            bad = at_back ? (c >= WIN - nbad) : (c < nbad);
            if (bad) begin
                step(1'b1, 1'b1, code);
                seen++;
            end else if (c % 3 == 0) begin
                step(1'b1, 1'b0, 2'b11);
            end else begin
                step(1'b1, 1'b1, (c % 2 == 1) ? 2'b01 : 2'b10);
            end
            if (c == WIN - 1) chk({tag, " R8 end"}, hi_ber, nbad > THR);
            else chk({tag, " R5/R6 run"}, hi_ber, seen > THR);
        end
    endtask

    task automatic quiet_window(input logic held, input string tag);
        for (int c = 0; c < WIN; c++) begin
            step(1'b1, 1'b1, 2'b10);
            if (c == WIN - 1) chk({tag, " R8 clear"}, hi_ber, 1'b0);
            else chk({tag, " R8 hold"}, hi_ber, held);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1'b1, 1'b1, 2'b00);
        step(1'b1, 1'b1, 2'b00);
        chk("R1 in reset", hi_ber, 1'b0);
        rst = 1'b0;
        step(1'b0, 1'b0, 2'b01);
        chk("R1 after reset", hi_ber, 1'b0);

        // Sweep: count 0..20, both illegal codes, front and back packing (R3 R5 R6 R7 R8)
        for (int n = 0; n <= 20; n++) begin
            for (int k = 0; k < 2; k++) begin
                for (int b = 0; b < 2; b++) begin
                    unlock_one();
                    chk("R9 restart", hi_ber, 1'b0);
                    run_window(n, (k == 0) ? 2'b00 : 2'b11, b[0], "R3 sweep");
                    quiet_window(n > THR, "R7 next");
                end
            end
        end

        // R2: a window full of strobed legal headers
        unlock_one();
        for (int c = 0; c < WIN; c++) step(1'b1, 1'b1, (c % 2 == 0) ? 2'b01 : 2'b10);
        chk("R2 legal only", hi_ber, 1'b0);

        // R4: 10 real errors plus 30 unstrobed illegal codes
        unlock_one();
        for (int c = 0; c < WIN; c++) step(1'b1, c < 10, (c % 2 == 0) ? 2'b00 : 2'b11);
        chk("R4 unstrobed", hi_ber, 1'b0);

        // R7: 10 errors at the back of one window, 10 at the front of the next
        unlock_one();
        for (int c = 0; c < 2 * WIN; c++)
            step(1'b1, 1'b1, (c >= WIN - 10 && c < WIN + 10) ? 2'b00 : 2'b01);
        chk("R7 split burst", hi_ber, 1'b0);

        // R9: lock loss while flagged, then relock with 10 errors
        unlock_one();
        for (int c = 0; c < 17; c++) step(1'b1, 1'b1, 2'b11);
        chk("R9 flagged", hi_ber, 1'b1);
        unlock_one();
        chk("R9 unlock clears", hi_ber, 1'b0);
        for (int c = 0; c < WIN; c++) step(1'b1, 1'b1, (c < 10) ? 2'b00 : 2'b01);
        chk("R9 relock fresh count", hi_ber, 1'b0);

        // R11: errors strobed while lock low are not carried forward
        for (int c = 0; c < 20; c++) step(1'b0, 1'b1, 2'b00);
        chk("R11 lock low", hi_ber, 1'b0);
        for (int c = 0; c < WIN; c++) step(1'b1, 1'b1, (c < 10) ? 2'b11 : 2'b10);
        chk("R11 after lock", hi_ber, 1'b0);

        // R10: every slot invalid; a wrapping 5-bit count would end at 8
        unlock_one();
        for (int c = 0; c < WIN; c++) step(1'b1, 1'b1, 2'b00);
        chk("R10 saturate end", hi_ber, 1'b1);
        quiet_window(1'b1, "R10 after");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule